// File: doc/BRIEF.md
# Audio Link Output Frame Serializer

This block is the transmit side of a controller for a serial audio codec link. On every rising edge of the bit clock it puts one bit of the outgoing frame on a serial data line and drives a frame marker line alongside it. Each frame is 256 bits long. A 16-bit tag slot comes first and is followed by twelve 20-bit payload slots. The tag slot holds a frame-valid flag and one valid flag per payload slot, so streams at different sample rates can share the fixed frame rate: a slot with nothing to send this frame is simply marked empty.

Upstream logic presents twelve payloads, their valid tags and a sample length for each slot. The block captures all of them into a shadow copy at the bit clock edge on which the frame marker rises, and it pulses a frame-start strobe on that same edge. Upstream logic can therefore load the next frame's data at any time during the current frame. Empty slots and the bits past a short sample's length are sent as zeros. A mono setting makes the right PCM slot (slot 4) carry exactly what the left PCM slot (slot 3) carries.

Top module: `audlink_frame_tx`

## Requirements
- R1: `sync_o` is high for exactly 16 consecutive bit clock cycles in every frame and low for the other 240, and it rises once every 256 cycles.
- R2: Frame bit 0 is the frame-valid flag. Frame bits 1 to 12 are the valid tags of slots 1 to 12, in that order. Frame bits 13 to 15 are always 0.
- R3: The frame-valid flag is 1 exactly when at least one effective slot tag of the captured frame is 1.
- R4: Slot k (k = 1..12) occupies frame bits 16+20(k-1) up to 35+20(k-1). It carries `slot_data_i[20(k-1)+19 : 20(k-1)]`, most significant bit first.
- R5: When a slot's effective tag is 0, all 20 of its bits are sent as 0, whatever its payload.
- R6: The 5-bit length field of slot k is `slot_width_i[5(k-1)+4 : 5(k-1)]`. A value W from 1 to 20 sends the top W payload bits and then 20-W zeros. A value of 0 or above 20 sends all 20 bits.
- R7: `sync_o` rises on the same edge that drives the last bit of the previous frame, and frame bit 0 follows on the next edge. `frame_start_o` is high for exactly the one cycle in which `sync_o` has just risen.
- R8: Tags, payloads, lengths and the mono setting are sampled only on the edge where `sync_o` rises. Changes to them at any other time do not affect the frame being sent.
- R9: With `mono_i` set at capture, slot 4 takes the tag, payload and length of slot 3, and its own inputs are ignored.
- R10: While `rst_i` is high, `sync_o`, `sdata_o` and `frame_start_o` are 0. On the first edge after reset is released, a new frame starts with `sync_o` and `frame_start_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; all outputs change on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| slot_tag_i | input | 12 | Valid tag per payload slot; bit k-1 is slot k |
| slot_data_i | input | 240 | Twelve 20-bit payloads; slot k in bits 20(k-1)+19 to 20(k-1) |
| slot_width_i | input | 60 | Twelve 5-bit sample lengths; slot k in bits 5(k-1)+4 to 5(k-1) |
| mono_i | input | 1 | Copy slot 3 into slot 4 for the captured frame |
| sync_o | output | 1 | Frame marker, high during the 16-bit tag phase |
| sdata_o | output | 1 | Serial frame data |
| frame_start_o | output | 1 | One-cycle strobe on the edge where the inputs were captured |

## Verification
The capture of a new frame and the transmission of the last bit of the old frame's slot 12 take place on the same clock edge. The shadow is rewritten on exactly the edge that still has to send the old copy's final bit. The bench provokes this by loading a new, different vector on every frame-start cycle while the previous vector had slot 12 valid at full length. It then judges frame bit 255 against the old vector and the next frame against the new one. The same step also confirms that input changes made just after capture leave the frame on the line untouched.

// File: rtl/audlink_pkg.sv
package audlink_pkg;

    localparam int DEF_NSLOT  = 12;
    localparam int DEF_SLOT_W = 20;
    localparam int DEF_TAG_W  = 16;

    // Length field decode: 0 or anything above the slot width means full width.
    function automatic int sample_len(input int w, input int full);
        return (w == 0 || w > full) ? full : w;
    endfunction

endpackage

// File: rtl/audlink_slot_locate.sv
module audlink_slot_locate #(
    parameter int NSLOT  = 12,
    parameter int SLOT_W = 20,
    parameter int TAG_W  = 16,
    parameter int CNT_W  = 8,
    parameter int TPW    = $clog2(TAG_W),
    parameter int SIW    = $clog2(NSLOT),
    parameter int BPW    = $clog2(SLOT_W)
) (
    input  logic [CNT_W-1:0] idx_i,
    output logic             in_tag_o,
    output logic [TPW-1:0]   tag_pos_o,
    output logic [SIW-1:0]   slot_o,
    output logic [BPW-1:0]   bit_pos_o
);

    logic [CNT_W-1:0] rel;
    logic [CNT_W-1:0] base;

    assign in_tag_o  = (idx_i < CNT_W'(TAG_W));
    assign tag_pos_o = idx_i[TPW-1:0];
    assign rel       = idx_i - CNT_W'(TAG_W);

    always_comb begin
        slot_o = '0;
        base   = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rel >= CNT_W'(i * SLOT_W)) begin
                slot_o = SIW'(i);
                base   = CNT_W'(i * SLOT_W);
            end
        end
        bit_pos_o = BPW'(rel - base);
    end

endmodule

// File: rtl/audlink_bit_pick.sv
module audlink_bit_pick
    import audlink_pkg::*;
#(
    parameter int NSLOT  = 12,
    parameter int SLOT_W = 20,
    parameter int TAG_W  = 16,
    parameter int WID_W  = $clog2(SLOT_W + 1),
    parameter int TPW    = $clog2(TAG_W),
    parameter int SIW    = $clog2(NSLOT),
    parameter int BPW    = $clog2(SLOT_W)
) (
    input  logic                         in_tag_i,
    input  logic [TPW-1:0]               tag_pos_i,
    input  logic [SIW-1:0]               slot_i,
    input  logic [BPW-1:0]               bit_pos_i,
    input  logic                         fv_i,
    input  logic [NSLOT-1:0]             tags_i,
    input  logic [NSLOT-1:0][SLOT_W-1:0] data_i,
    input  logic [NSLOT-1:0][WID_W-1:0]  wid_i,
    output logic                         bit_o
);

    int eff_len;

    always_comb begin
        bit_o   = 1'b0;
        eff_len = SLOT_W;
        if (in_tag_i) begin
            if (tag_pos_i == '0) begin
                bit_o = fv_i;
            end else if (int'(tag_pos_i) <= NSLOT) begin
                bit_o = tags_i[tag_pos_i - 1'b1];
            end
        end else if (int'(slot_i) < NSLOT) begin
            eff_len = sample_len(int'(wid_i[slot_i]), SLOT_W);
            if (tags_i[slot_i] && (int'(bit_pos_i) < eff_len)) begin
                bit_o = data_i[slot_i][BPW'(SLOT_W - 1) - bit_pos_i];
            end
        end
    end

endmodule

// File: rtl/audlink_frame_tx.sv
module audlink_frame_tx
    import audlink_pkg::*;
#(
    parameter int NSLOT      = DEF_NSLOT,
    parameter int SLOT_W     = DEF_SLOT_W,
    parameter int TAG_W      = DEF_TAG_W,
    parameter int LEFT_SLOT  = 2,
    parameter int RIGHT_SLOT = 3
) (
    input  logic                                  clk_i,
    input  logic                                  rst_i,
    input  logic [NSLOT-1:0]                      slot_tag_i,
    input  logic [NSLOT*SLOT_W-1:0]               slot_data_i,
    input  logic [NSLOT*$clog2(SLOT_W+1)-1:0]     slot_width_i,
    input  logic                                  mono_i,
    output logic                                  sync_o,
    output logic                                  sdata_o,
    output logic                                  frame_start_o
);

    localparam int WID_W     = $clog2(SLOT_W + 1);
    localparam int FRAME_LEN = TAG_W + NSLOT * SLOT_W;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int TPW       = $clog2(TAG_W);
    localparam int SIW       = $clog2(NSLOT);
    localparam int BPW       = $clog2(SLOT_W);

    typedef struct packed {
        logic [CNT_W-1:0]             ph;
        logic                         sync;
        logic                         sdata;
        logic                         fstart;
        logic                         fv;
        logic [NSLOT-1:0]             tag;
        logic [NSLOT-1:0][SLOT_W-1:0] data;
        logic [NSLOT-1:0][WID_W-1:0]  wid;
    } tx_state_t;

    tx_state_t st_d, st_q;

    logic [NSLOT-1:0][SLOT_W-1:0] in_data;
    logic [NSLOT-1:0][WID_W-1:0]  in_wid;
    logic [NSLOT-1:0]             eff_tag;
    logic [NSLOT-1:0][SLOT_W-1:0] eff_data;
    logic [NSLOT-1:0][WID_W-1:0]  eff_wid;

    assign in_data = slot_data_i;
    assign in_wid  = slot_width_i;

    // Mono duplication is applied on the way into the shadow copy.
    for (genvar s = 0; s < NSLOT; s++) begin : g_eff
        if (s == RIGHT_SLOT) begin : g_right
            assign eff_tag[s]  = mono_i ? slot_tag_i[LEFT_SLOT] : slot_tag_i[s];
            assign eff_data[s] = mono_i ? in_data[LEFT_SLOT]    : in_data[s];
            assign eff_wid[s]  = mono_i ? in_wid[LEFT_SLOT]     : in_wid[s];
        end else begin : g_pass
            assign eff_tag[s]  = slot_tag_i[s];
            assign eff_data[s] = in_data[s];
            assign eff_wid[s]  = in_wid[s];
        end
    end

    // Position of the bit driven on the coming edge: phase 0 still sends
    // the last bit of the previous frame.
    logic [CNT_W-1:0] bit_idx;
    logic             loc_in_tag;
    logic [TPW-1:0]   loc_tag_pos;
    logic [SIW-1:0]   loc_slot;
    logic [BPW-1:0]   loc_bit_pos;
    logic             next_bit;

    assign bit_idx = (st_q.ph == '0) ? CNT_W'(FRAME_LEN - 1) : st_q.ph - 1'b1;

    audlink_slot_locate #(
        .NSLOT (NSLOT),
        .SLOT_W(SLOT_W),
        .TAG_W (TAG_W),
        .CNT_W (CNT_W)
    ) u_locate (
        .idx_i    (bit_idx),
        .in_tag_o (loc_in_tag),
        .tag_pos_o(loc_tag_pos),
        .slot_o   (loc_slot),
        .bit_pos_o(loc_bit_pos)
    );

    audlink_bit_pick #(
        .NSLOT (NSLOT),
        .SLOT_W(SLOT_W),
        .TAG_W (TAG_W)
    ) u_pick (
        .in_tag_i (loc_in_tag),
        .tag_pos_i(loc_tag_pos),
        .slot_i   (loc_slot),
        .bit_pos_i(loc_bit_pos),
        .fv_i     (st_q.fv),
        .tags_i   (st_q.tag),
        .data_i   (st_q.data),
        .wid_i    (st_q.wid),
        .bit_o    (next_bit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ph     = (st_q.ph == CNT_W'(FRAME_LEN - 1)) ? '0 : st_q.ph + 1'b1;
        st_d.sync   = (st_q.ph < CNT_W'(TAG_W));
        st_d.sdata  = next_bit;
        st_d.fstart = (st_q.ph == '0);
        if (st_q.ph == '0) begin
            st_d.tag  = eff_tag;
            st_d.data = eff_data;
            st_d.wid  = eff_wid;
            st_d.fv   = |eff_tag;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o        = st_q.sync;
    assign sdata_o       = st_q.sdata;
    assign frame_start_o = st_q.fstart;

endmodule

// File: rtl/audlink_frame_tx_chk.sv
module audlink_frame_tx_chk #(
    parameter int TAG_W     = 16,
    parameter int NSLOT     = 12,
    parameter int FRAME_LEN = 256
) (
    input logic clk_i,
    input logic rst_i,
    input logic sync_o,
    input logic sdata_o,
    input logic frame_start_o
);

    logic [9:0] hi_run_q;
    logic [9:0] gap_q;
    logic       prev_q;
    logic       seen_q;
    logic       fv_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_run_q <= '0;
            gap_q    <= '0;
            prev_q   <= 1'b0;
            seen_q   <= 1'b0;
            fv_q     <= 1'b0;
        end else begin
            prev_q   <= sync_o;
            hi_run_q <= sync_o ? hi_run_q + 1'b1 : '0;
            if (sync_o && !prev_q) begin
                gap_q  <= 10'd1;
                seen_q <= 1'b1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
            if (seen_q && gap_q == 10'd1) begin
                fv_q <= sdata_o;
            end
        end
    end

    // R1
    sync_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sync_o) |-> (hi_run_q == 10'(TAG_W)));

    // R1
    frame_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(sync_o) && seen_q) |-> (gap_q == 10'(FRAME_LEN)));

    // R7
    start_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start_o == $rose(sync_o));

    // R2
    reserved_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && gap_q >= 10'(NSLOT + 2) && gap_q <= 10'(TAG_W)) |-> !sdata_o);

    // R3
    empty_frame_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && !fv_q && gap_q >= 10'd2 && gap_q <= 10'(NSLOT + 1)) |-> !sdata_o);

    // R10
    reset_quiet_chk: assert property (@(posedge clk_i)
        rst_i |=> (!sync_o && !sdata_o && !frame_start_o));

endmodule

bind audlink_frame_tx audlink_frame_tx_chk #(
    .TAG_W    (TAG_W),
    .NSLOT    (NSLOT),
    .FRAME_LEN(TAG_W + NSLOT * SLOT_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .sync_o       (sync_o),
    .sdata_o      (sdata_o),
    .frame_start_o(frame_start_o)
);

// File: tb/audlink_frame_tx_test.sv
module audlink_frame_tx_test;

    localparam int CLK_P = 10;
    localparam int NS    = 12;
    localparam int SW    = 20;
    localparam int WW    = 5;
    localparam int FL    = 256;
    localparam int NV    = 9;

    // Vector fields: tags[22:11] (bit 11 = slot 1), mono[10], seed[9:2], length mode[1:0]
    localparam logic [22:0] VEC [NV] = '{
        {12'h000, 1'b0, 8'd1, 2'd0},
        {12'hFFF, 1'b0, 8'd2, 2'd0},
        {12'hAAA, 1'b0, 8'd3, 2'd1},
        {12'h004, 1'b1, 8'd4, 2'd0},
        {12'hFFF, 1'b1, 8'd5, 2'd2},
        {12'h001, 1'b0, 8'd6, 2'd1},
        {12'h800, 1'b0, 8'd7, 2'd3},
        {12'h5F3, 1'b0, 8'd8, 2'd1},
        {12'h008, 1'b1, 8'd9, 2'd0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NS-1:0]    tag_i;
    logic [NS*SW-1:0] data_i;
    logic [NS*WW-1:0] wid_i;
    logic             mono_i;
    logic             sync_o;
    logic             sdata_o;
    logic             fs_o;

    int checks = 0;
    int errors = 0;

    logic [NS-1:0] et;
    logic [SW-1:0] ed [NS];
    logic [WW-1:0] ew [NS];
    logic          emono;
    logic          got [FL];
    logic          sg  [FL];
    logic          fg  [FL];

    always #(CLK_P / 2) clk = ~clk;

    audlink_frame_tx uut (
        .clk_i        (clk),
        .rst_i        (rst),
        .slot_tag_i   (tag_i),
        .slot_data_i  (data_i),
        .slot_width_i (wid_i),
        .mono_i       (mono_i),
        .sync_o       (sync_o),
        .sdata_o      (sdata_o),
        .frame_start_o(fs_o)
    );

    function automatic logic [SW-1:0] gen_data(input int seed, input int s);
        logic [31:0] t;
        t = 32'(seed) * 32'd2654435 + 32'(s) * 32'd40503 + 32'd7919;
        return t[27:8];
    endfunction

    function automatic logic [WW-1:0] gen_wid(input int mode, input int seed, input int s);
        case (mode)
            0:       return WW'(20);
            1:       return WW'((s * 7 + seed) % 32);
            2:       return WW'(8);
            default: return WW'(31);
        endcase
    endfunction

    function automatic int eff_len(input logic [WW-1:0] w);
        return (w == 0 || int'(w) > SW) ? SW : int'(w);
    endfunction

    task automatic drive(input logic [22:0] v);
        tag_i  = v[22:11];
        mono_i = v[10];
        for (int s = 0; s < NS; s++) begin
            data_i[s*SW +: SW] = gen_data(int'(v[9:2]), s);
            wid_i[s*WW +: WW]  = gen_wid(int'(v[1:0]), int'(v[9:2]), s);
        end
    endtask

    task automatic load_exp(input logic [22:0] v);
        emono = v[10];
        for (int s = 0; s < NS; s++) begin
            et[s] = v[11 + s];
            ed[s] = gen_data(int'(v[9:2]), s);
            ew[s] = gen_wid(int'(v[1:0]), int'(v[9:2]), s);
        end
        if (emono) begin
            et[3] = et[2];
            ed[3] = ed[2];
            ew[3] = ew[2];
        end
    endtask

    function automatic logic exp_bit(input int i);
        int s;
        int j;
        if (i == 0) return |et;
        if (i <= NS) return et[i - 1];
        if (i < 16) return 1'b0;
        s = (i - 16) / SW;
        j = (i - 16) % SW;
        if (!et[s] || j >= eff_len(ew[s])) return 1'b0;
        return ed[s][SW - 1 - j];
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic collect();
        for (int i = 0; i < FL; i++) begin
            @(negedge clk);
            got[i] = sdata_o;
            sg[i]  = sync_o;
            fg[i]  = fs_o;
        end
    endtask

    task automatic judge_frame(input int v);
        int ms;
        int mf;
        int mall;
        logic [NS-1:0] tact;
        logic [SW-1:0] sa;
        logic [SW-1:0] se;
        string req;
        ms = 0; mf = 0; mall = 0;
        for (int i = 0; i < FL; i++) begin
            if (sg[i] != ((i < 15) || (i == FL - 1))) ms++;
            if (fg[i] != (i == FL - 1)) mf++;
            if (got[i] != exp_bit(i)) mall++;
        end
        chk(ms == 0, $sformatf("R1 sync pattern vec%0d", v), 32'(ms), 0);
        chk(mf == 0, $sformatf("R7 start strobe vec%0d", v), 32'(mf), 0);
        chk(got[0] == (|et), $sformatf("R3 frame valid vec%0d", v), 32'(got[0]), 32'(|et));
        for (int k = 0; k < NS; k++) tact[k] = got[k + 1];
        chk(tact == et, $sformatf("R2 tag bits vec%0d", v), 32'(tact), 32'(et));
        chk({got[13], got[14], got[15]} == 3'b000, $sformatf("R2 reserved vec%0d", v),
            32'({got[13], got[14], got[15]}), 0);
        for (int s = 0; s < NS; s++) begin
            for (int j = 0; j < SW; j++) begin
                sa[SW - 1 - j] = got[16 + s * SW + j];
                se[SW - 1 - j] = exp_bit(16 + s * SW + j);
            end
            if (emono && s == 3) req = "R9";
            else if (!et[s]) req = "R5";
            else if (eff_len(ew[s]) < SW) req = "R6";
            else req = "R4";
            chk(sa == se, $sformatf("%s slot%0d vec%0d", req, s + 1, v), 32'(sa), 32'(se));
        end
        // R8: inputs were replaced on the capture cycle, frame must still match
        chk(mall == 0, $sformatf("R8 held frame vec%0d", v), 32'(mall), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        drive(VEC[0]);
        repeat (3) @(negedge clk);
        chk(!sync_o && !sdata_o && !fs_o, "R10 outputs in reset",
            32'({sync_o, sdata_o, fs_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sync_o && fs_o, "R10 first frame after reset", 32'({sync_o, fs_o}), 32'b11);

        // Table walk: each frame checked against the vector captured at its start,
        // while the next vector is already on the inputs.
        for (int v = 0; v < NV; v++) begin
            load_exp(VEC[v]);
            drive(VEC[(v + 1) % NV]);
            collect();
            judge_frame(v);
        end

        // Directed: reset in mid-frame, then frame restart and marker length.
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!sync_o && !sdata_o && !fs_o, "R10 mid-frame reset", 32'({sync_o, sdata_o, fs_o}), 0);
        repeat (2) @(negedge clk);
        chk(!sync_o && !sdata_o && !fs_o, "R10 held in reset", 32'({sync_o, sdata_o, fs_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sync_o && fs_o, "R10 restart after reset", 32'({sync_o, fs_o}), 32'b11);
        hi = 0;
        for (int i = 0; i < 300; i++) begin
            if (!sync_o) break;
            hi++;
            @(negedge clk);
        end
        chk(hi == 16, "R1 marker length after restart", 32'(hi), 32'd16);
        @(negedge clk);
        chk(!fs_o, "R7 strobe single cycle", 32'(fs_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule